// File: doc/BRIEF.md
# MSI Ingress Capture Controller

This block sits beside the inbound request path of a PCIe root port and watches memory writes arriving from the link. A write whose 64-bit address equals a programmed target address, and whose data word is a vector number below 64, is treated as a message-signalled interrupt. The write is absorbed and the matching vector's bit is set in a 64-bit pending array. The array is split into a low word that holds vectors 0 to 31 and a high word that holds vectors 32 to 63. Every other write leaves on a pass-through port unchanged, in the same cycle, as ordinary traffic.

Each word has a mask register in which a 1 enables a vector. Each word also has its own level interrupt line, which is high while any pending bit in that word is enabled. Software uses a simple 32-bit register port with a combinational read. It programs the target address, turns decoding and capture on through a control register, and acknowledges vectors by writing ones to the status words. A read-only capability register reports that the function is present.

Top module: `msi_ingress_capture`

## Requirements
- R1: After reset every status bit, every mask bit, the control register and the target address read as 0, and both interrupt lines are low. The capability register at offset 0x300 reads 0x00000001 at all times, and writes to it have no effect.
- R2: Decoding is on when control bit 0 is 1, and capture is on when control bit 15 is 1. With both on, a write with rq_valid high, rq_addr equal to the target address and rq_data below 64 sets one status bit from the next clock edge. Vector v below 32 is bit v of the low word at offset 0x440. Vector v from 32 to 63 is bit v-32 of the high word at offset 0x444.
- R3: A register write to a status word clears each bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R4: irq_lo equals the OR over the low word of status AND mask, where the low mask is at offset 0x448. irq_hi follows the same rule for the high word, with the high mask at offset 0x44C. A mask bit of 1 enables its vector.
- R5: A vector is captured into status whether or not its mask bit is 1. Setting the mask later raises the line.
- R6: When a capture and a software clear reach the same status bit on the same clock edge, the bit ends up set.
- R7: A write whose address differs from the target in any of its 64 bits, or whose data is 64 or more, changes no status bit. It appears on pt_valid, pt_addr and pt_data in the same cycle.
- R8: With control bit 0 at 0, every write passes through and no status bit changes. With bit 0 at 1 and bit 15 at 0, a matching write is absorbed, with pt_valid low, but no status bit changes.
- R9: The target address is written and read back at 0x310 for the low half and 0x314 for the high half. Only bits 0 and 15 of the control register at 0x308 are stored, and its other bits read as 0. Reads of unmapped offsets return 0.
- R10: A write that is captured as a message is absorbed: pt_valid is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rq_valid | input | 1 | Inbound memory write present this cycle |
| rq_addr | input | 64 | Inbound write address |
| rq_data | input | 32 | Inbound write data |
| pt_valid | output | 1 | Write forwarded as ordinary traffic |
| pt_addr | output | 64 | Forwarded address |
| pt_data | output | 32 | Forwarded data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_lo | output | 1 | Level interrupt for vectors 0 to 31 |
| irq_hi | output | 1 | Level interrupt for vectors 32 to 63 |

## Verification
Pass-through and register reads are combinational, so they are due in the same cycle the stimulus is applied. Captures, clears, mask and control writes take effect on the next rising edge, and the interrupt lines follow that edge without further delay. The bench applies inputs just after a rising edge. Its behavioural model updates on that edge and sees the inputs that were present before it. Outputs are compared on the falling edge between. Every cycle therefore checks the lines against state that already includes the previous edge's writes and captures, and checks pass-through against the current inputs.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int DW       = 32;
  localparam int AW       = 64;
  localparam int REG_AW   = 12;
  localparam int NUM_BANK = 2;
  localparam int NUM_VEC  = NUM_BANK * DW;
  localparam int VEC_W    = $clog2(NUM_VEC);
  localparam int BIT_W    = $clog2(DW);
  localparam int BSEL_W   = VEC_W - BIT_W;

  localparam logic [REG_AW-1:0] OFS_CAP     = 12'h300;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 12'h308;
  localparam logic [REG_AW-1:0] OFS_TGT_LO  = 12'h310;
  localparam logic [REG_AW-1:0] OFS_TGT_HI  = 12'h314;
  localparam logic [REG_AW-1:0] OFS_STAT0   = 12'h440;
  localparam logic [REG_AW-1:0] OFS_MASK0   = 12'h448;

  localparam int CTRL_DEC_BIT = 0;
  localparam int CTRL_CAP_BIT = 15;
  localparam logic [DW-1:0] CAP_VALUE = 32'h0000_0001;

  typedef struct packed {
    logic             dec_en;
    logic             cap_en;
  } ctrl_t;
endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/msi_addr_match.sv
module msi_addr_match
  import msi_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rq_valid,
  input  logic [AW-1:0]    rq_addr,
  input  logic [DW-1:0]    rq_data,
  input  logic [AW-1:0]    target,
  input  logic             dec_en,
  output logic             hit,
  output logic [VEC_W-1:0] vec,
  output logic             pass_valid
);
  localparam logic [DW-1:0] VEC_LIMIT = DW'(NUM_VEC);

  logic addr_eq;
  logic in_range;

  always_comb begin
    addr_eq    = (rq_addr == target);
    in_range   = (rq_data < VEC_LIMIT);
    hit        = rq_valid & dec_en & addr_eq & in_range;
    vec        = rq_data[VEC_W-1:0];
    pass_valid = rq_valid & ~hit;
  end

  // R7: a write to any other address is always forwarded
  assert_addr_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && (rq_addr != target)) |-> pass_valid);

  // R7: out-of-range vector numbers are never decoded
  assert_range_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && (rq_data >= VEC_LIMIT)) |-> (pass_valid && !hit));
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank
  import msi_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_valid,
  input  logic [BIT_W-1:0] cap_bit,
  input  logic             clr_we,
  input  logic [DW-1:0]    clr_data,
  input  logic             mask_we,
  input  logic [DW-1:0]    mask_data,
  output logic [DW-1:0]    status,
  output logic [DW-1:0]    mask,
  output logic             irq
);
  logic [DW-1:0] stat_q, stat_d;
  logic [DW-1:0] mask_q, mask_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_we)    stat_d = stat_d & ~clr_data;
    if (cap_valid) stat_d[cap_bit] = 1'b1;
    mask_d = mask_q;
    if (mask_we)   mask_d = mask_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq    = |(stat_q & mask_q);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> stat_q[$past(cap_bit)]);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !cap_valid) |=> ((stat_q & $past(clr_data)) == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && !cap_valid) |=> $stable(stat_q));

  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && clr_we && clr_data[cap_bit]) |=> stat_q[$past(cap_bit)]);
endmodule

// File: rtl/msi_ingress_capture.sv
module msi_ingress_capture
  import msi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rq_valid,
  input  logic [AW-1:0]     rq_addr,
  input  logic [DW-1:0]     rq_data,
  output logic              pt_valid,
  output logic [AW-1:0]     pt_addr,
  output logic [DW-1:0]     pt_data,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  logic srst_n;

  msi_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .srst_n(srst_n)
  );

  ctrl_t         ctrl_q, ctrl_d;
  logic [AW-1:0] tgt_q, tgt_d;

  always_comb begin
    ctrl_d = ctrl_q;
    tgt_d  = tgt_q;
    if (reg_we) begin
      if (reg_addr == OFS_CTRL) begin
        ctrl_d.dec_en = reg_wdata[CTRL_DEC_BIT];
        ctrl_d.cap_en = reg_wdata[CTRL_CAP_BIT];
      end
      if (reg_addr == OFS_TGT_LO) tgt_d[DW-1:0]    = reg_wdata;
      if (reg_addr == OFS_TGT_HI) tgt_d[AW-1:DW]   = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
      tgt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      tgt_q  <= tgt_d;
    end
  end

  logic             hit_w;
  logic [VEC_W-1:0] vec_w;
  logic             pass_w;

  msi_addr_match u_match (
    .clk       (clk),
    .rst_n     (srst_n),
    .rq_valid  (rq_valid),
    .rq_addr   (rq_addr),
    .rq_data   (rq_data),
    .target    (tgt_q),
    .dec_en    (ctrl_q.dec_en),
    .hit       (hit_w),
    .vec       (vec_w),
    .pass_valid(pass_w)
  );

  assign pt_valid = pass_w;
  assign pt_addr  = rq_addr;
  assign pt_data  = rq_data;

  logic [DW-1:0]       stat_w [NUM_BANK];
  logic [DW-1:0]       mask_w [NUM_BANK];
  logic [NUM_BANK-1:0] irq_w;
  logic [NUM_VEC-1:0]  stat_flat;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic bank_cap, bank_clr, bank_msk;
    always_comb begin
      bank_cap = hit_w & ctrl_q.cap_en & (vec_w[VEC_W-1:BIT_W] == BSEL_W'(b));
      bank_clr = reg_we & (reg_addr == OFS_STAT0 + REG_AW'(4*b));
      bank_msk = reg_we & (reg_addr == OFS_MASK0 + REG_AW'(4*b));
    end

    msi_vec_bank u_bank (
      .clk      (clk),
      .rst_n    (srst_n),
      .cap_valid(bank_cap),
      .cap_bit  (vec_w[BIT_W-1:0]),
      .clr_we   (bank_clr),
      .clr_data (reg_wdata),
      .mask_we  (bank_msk),
      .mask_data(reg_wdata),
      .status   (stat_w[b]),
      .mask     (mask_w[b]),
      .irq      (irq_w[b])
    );

    assign stat_flat[b*DW +: DW] = stat_w[b];
  end

  assign irq_lo = irq_w[0];
  assign irq_hi = irq_w[NUM_BANK-1];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CAP)    reg_rdata = CAP_VALUE;
    if (reg_addr == OFS_CTRL) begin
      reg_rdata[CTRL_DEC_BIT] = ctrl_q.dec_en;
      reg_rdata[CTRL_CAP_BIT] = ctrl_q.cap_en;
    end
    if (reg_addr == OFS_TGT_LO) reg_rdata = tgt_q[DW-1:0];
    if (reg_addr == OFS_TGT_HI) reg_rdata = tgt_q[AW-1:DW];
    for (int b = 0; b < NUM_BANK; b++) begin
      if (reg_addr == OFS_STAT0 + REG_AW'(4*b)) reg_rdata = stat_w[b];
      if (reg_addr == OFS_MASK0 + REG_AW'(4*b)) reg_rdata = mask_w[b];
    end
  end

  assert_dec_off_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (rq_valid && !ctrl_q.dec_en) |-> pt_valid);

  assert_cap_off_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (!ctrl_q.cap_en && !reg_we) |=> $stable(stat_flat));

  assert_cap_const_R1: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_addr == OFS_CAP) |-> (reg_rdata == CAP_VALUE));

  assert_absorb_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (rq_valid && ctrl_q.cap_en && $rose(stat_flat[0])) |-> $past(!pt_valid));
endmodule

// File: tb/msi_ingress_capture_tb.sv
module msi_ingress_capture_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rq_valid = 1'b0;
  logic [63:0] rq_addr = '0;
  logic [31:0] rq_data = '0;
  logic        pt_valid;
  logic [63:0] pt_addr;
  logic [31:0] pt_data;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi;

  always #(CLK_P/2) clk = ~clk;

  msi_ingress_capture u_dut (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_data(rq_data),
    .pt_valid(pt_valid), .pt_addr(pt_addr), .pt_data(pt_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  int checks = 0;
  int errors = 0;
  bit run = 0;

  // behavioural reference
  logic [63:0] m_stat, m_mask, m_tgt;
  bit          m_dec, m_cap;

  function automatic bit m_hit();
    return rq_valid && m_dec && (rq_addr == m_tgt) && (rq_data < 64);
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a)
      12'h300: return 32'h1;
      12'h308: return {16'h0, m_cap, 14'h0, m_dec};
      12'h310: return m_tgt[31:0];
      12'h314: return m_tgt[63:32];
      12'h440: return m_stat[31:0];
      12'h444: return m_stat[63:32];
      12'h448: return m_mask[31:0];
      12'h44C: return m_mask[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = '0; m_mask = '0; m_tgt = '0; m_dec = 0; m_cap = 0;
    end else begin
      bit h;
      logic [63:0] ns;
      h  = m_hit();
      ns = m_stat;
      if (reg_we) begin
        case (reg_addr)
          12'h308: begin m_dec = reg_wdata[0]; m_cap = reg_wdata[15]; end
          12'h310: m_tgt[31:0]  = reg_wdata;
          12'h314: m_tgt[63:32] = reg_wdata;
          12'h440: ns[31:0]  = ns[31:0]  & ~reg_wdata;
          12'h444: ns[63:32] = ns[63:32] & ~reg_wdata;
          12'h448: m_mask[31:0]  = reg_wdata;
          12'h44C: m_mask[63:32] = reg_wdata;
          default: ;
        endcase
      end
      if (h && m_cap) ns[rq_data[5:0]] = 1'b1;   // capture beats clear (R6)
      m_stat = ns;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (run) begin
      chk("R4 irq_lo", irq_lo, |(m_stat[31:0] & m_mask[31:0]));
      chk("R4 irq_hi", irq_hi, |(m_stat[63:32] & m_mask[63:32]));
      chk("R10 pt_valid", pt_valid, rq_valid && !m_hit());
      if (pt_valid) chk("R7 pt_fields", {pt_addr ^ rq_addr} | {32'h0, pt_data ^ rq_data}, 64'h0);
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    reg_we = 0; rq_valid = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    rq_valid = 0; reg_we = 1; reg_addr = a; reg_wdata = d;
    idle();
  endtask

  task automatic msi(logic [63:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 0; rq_valid = 1; rq_addr = a; rq_data = d;
    idle();
  endtask

  task automatic rd(logic [11:0] a, string tag);
    @(posedge clk); #1;
    reg_we = 0; rq_valid = 0; reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, m_read(a));
  endtask

  task automatic rd_lit(logic [11:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    reg_we = 0; rq_valid = 0; reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  localparam logic [63:0] TGT = 64'hFEDC_0000_1234_5670;

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1 run = 1;

    // R1 reset state
    rd_lit(12'h300, 32'h1, "R1 capability");
    rd_lit(12'h308, 32'h0, "R1 control");
    rd_lit(12'h440, 32'h0, "R1 status lo");
    rd_lit(12'h444, 32'h0, "R1 status hi");
    rd_lit(12'h448, 32'h0, "R1 mask lo");
    rd_lit(12'h314, 32'h0, "R1 target hi");
    chk("R1 irq idle", {irq_hi, irq_lo}, 2'b00);
    wr(12'h300, 32'h0);
    rd_lit(12'h300, 32'h1, "R1 capability read-only");

    // R9 register map
    wr(12'h310, TGT[31:0]);
    wr(12'h314, TGT[63:32]);
    rd_lit(12'h310, TGT[31:0], "R9 target lo");
    rd_lit(12'h314, TGT[63:32], "R9 target hi");
    wr(12'h308, 32'hFFFF_FFFF);
    rd_lit(12'h308, 32'h0000_8001, "R9 control bits");
    rd_lit(12'h50C, 32'h0, "R9 unmapped");
    wr(12'h308, 32'h0);

    // R8 decoding off, then capture off
    msi(TGT, 32'd3);
    rd_lit(12'h440, 32'h0, "R8 decode off no capture");
    wr(12'h308, 32'h0000_0001);
    msi(TGT, 32'd4);
    rd_lit(12'h440, 32'h0, "R8 capture off no status");
    wr(12'h308, 32'h0000_8001);

    // R2 / R5 captures with mask clear
    msi(TGT, 32'd0);
    msi(TGT, 32'd31);
    msi(TGT, 32'd32);
    msi(TGT, 32'd63);
    rd_lit(12'h440, 32'h8000_0001, "R2 low word");
    rd_lit(12'h444, 32'h8000_0001, "R2 high word");
    chk("R5 masked captured, irq low", {irq_hi, irq_lo}, 2'b00);

    // R4 masks
    wr(12'h448, 32'h8000_0000);
    @(negedge clk); chk("R4 irq_lo enabled", irq_lo, 1'b1);
    wr(12'h44C, 32'h0000_0020);
    @(negedge clk); chk("R4 irq_hi unmatched mask", irq_hi, 1'b0);
    wr(12'h44C, 32'h8000_0000);
    @(negedge clk); chk("R4 irq_hi enabled", irq_hi, 1'b1);

    // R3 write-one-to-clear
    wr(12'h440, 32'h0000_0001);
    rd_lit(12'h440, 32'h8000_0000, "R3 clear one bit");
    wr(12'h440, 32'h0);
    rd_lit(12'h440, 32'h8000_0000, "R3 zero write keeps");
    wr(12'h440, 32'h8000_0000);
    @(negedge clk); chk("R3 irq_lo drops after clear", irq_lo, 1'b0);

    // R6 capture and clear in one cycle
    @(posedge clk); #1;
    rq_valid = 1; rq_addr = TGT; rq_data = 32'd7;
    reg_we = 1; reg_addr = 12'h440; reg_wdata = 32'h0000_0080;
    idle();
    rd_lit(12'h440, 32'h0000_0080, "R6 capture wins");

    // R7 ignored writes
    msi(TGT, 32'd64);
    msi(TGT, 32'hFFFF_FFFF);
    msi(TGT + 64'd4, 32'd9);
    msi(TGT ^ 64'h8000_0000_0000_0000, 32'd40);
    rd_lit(12'h440, 32'h0000_0080, "R7 low unchanged");
    rd_lit(12'h444, 32'h8000_0001, "R7 high unchanged");

    // mixed traffic against the model (R2 R3 R4 R7)
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      rq_valid = ($urandom_range(0, 2) != 0);
      rq_addr  = ($urandom_range(0, 3) != 0) ? TGT : {$urandom, $urandom};
      rq_data  = $urandom_range(0, 70);
      reg_we   = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 3))
        0: reg_addr = 12'h440;
        1: reg_addr = 12'h444;
        2: reg_addr = 12'h448;
        default: reg_addr = 12'h44C;
      endcase
      reg_wdata = $urandom;
    end
    idle();
    rd(12'h440, "R2 final low");
    rd(12'h444, "R2 final high");
    rd(12'h448, "R4 final mask lo");
    rd(12'h44C, "R4 final mask hi");

    run = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule